// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Level-Compare Interrupts

The block gives software control of a bank of general-purpose pins over a small 32-bit word-addressed bus. Each pin has its own bits in an output register, an output-enable register, an alternate-function control register, pull-up and pull-down enable registers, an interrupt mask register and an interrupt polarity register. Pad levels cross into the clock domain through a two-flop synchronizer. Reads of the input register return those synchronized levels, whatever the direction of the pin.

All seven per-pin registers change only through a masked write. Each register has two words on the bus: a mask word, which stores a selector, and a value word. A write to the value word changes only the bits that the stored selector marks. A pin flags an interrupt while its synchronized level differs from its polarity bit and its mask bit is set. The flags of all pins are ORed, gated by a global enable bit, and registered onto one interrupt line. Software services a pin by writing the pin's present level into its polarity bit. The next transition in either direction then fires again, so each pin works as an any-edge detector.

Top module: `gpio_ctl`

## Requirements
- R1: After reset every register and stored mask reads 0, `irq` is 0 and `pad_oe` is all zeros.
- R2: A write to a value word sets the register to (old AND NOT m) OR (wdata AND m), where m is the selector last written to that register's mask word. A read of the mask word returns m.
- R3: `pad_oe` equals the output-enable register and `pad_o` equals the output register. A 0 bit in output-enable leaves the pin undriven (an input), and a 1 bit drives the output bit onto it.
- R4: The input word (offset 0x00) returns `pad_i` through two flops. A pad change made between edges is seen by a read after the second rising edge and not after the first, whatever the output-enable setting.
- R5: The pending vector is (synchronized input XOR polarity) AND interrupt-mask. `irq` is registered: it rises at the third rising edge after a pad change that sets a pending bit. Pins with mask 0 never raise `irq`.
- R6: Writing a pin's present level into its polarity bit clears its pending bit, and `irq` drops one edge later. The pin's next transition in the opposite direction raises `irq` again.
- R7: Bit 0 of the enable word (offset 0x04) gates `irq`. While it is 0, `irq` stays 0 whatever the pending vector. Setting it makes `irq` follow the pending vector again.
- R8: The alternate-function, pull-up and pull-down registers drive `pad_alt`, `pad_pu` and `pad_pd`. Each is written independently of the others.
- R9: Byte offsets of the mask/value word pairs: output 0x08/0x0C, output-enable 0x10/0x14, alternate function 0x18/0x1C, pull-up 0x20/0x24, pull-down 0x28/0x2C, interrupt mask 0x30/0x34, polarity 0x38/0x3C.
- R10: Data bits at and above NPINS read 0 and are ignored on write. The enable word reads only bit 0. Addresses with a nonzero low two bits read 0 and write nothing. Writes to the input word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_i | input | NPINS | Pad input levels |
| pad_o | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Pull-up enables |
| pad_pd | output | NPINS | Pull-down enables |
| pad_alt | output | NPINS | Alternate-function selects |
| irq | output | 1 | Registered interrupt level |

## Verification
The hardest case to reach is the re-arm cycle. A pin must fire on one edge. Its pending bit must then clear only through a polarity write that matches the level, and the opposite edge must fire it again, while an unmasked neighbour and an unmasked toggle must leave the line quiet. The bench sets up a masked pin and a stored polarity selector through the mask words. It then steps the pad, samples `irq` on the exact edge counts that the two-flop synchronizer and the output register add, writes the polarity, and reverses the pad. The gating bit is toggled while a pin is still pending, to show that the line follows the gate and not stale state.

// File: rtl/gpio_ctl.sv
module gpio_ctl #(
  parameter int NPINS = 16,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  output logic [NPINS-1:0] pad_alt,
  output logic             irq
);
  localparam int NREG   = 7;
  localparam int R_OUT  = 0;
  localparam int R_OE   = 1;
  localparam int R_ALT  = 2;
  localparam int R_PU   = 3;
  localparam int R_PD   = 4;
  localparam int R_IMSK = 5;
  localparam int R_IPOL = 6;

  logic [NPINS-1:0] creg  [NREG];
  logic [NPINS-1:0] csel  [NREG];
  logic [NPINS-1:0] sync1, in_sync;
  logic             gen_en;
  logic             irq_q;

  wire              aligned = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 6) == '0);
  wire [3:0]        word    = bus_addr[5:2];
  wire [2:0]        slot    = bus_addr[5:3];
  wire              is_val  = bus_addr[2];
  wire              wr      = bus_en & bus_we & aligned;
  wire [NPINS-1:0]  wbits   = bus_wdata[NPINS-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        creg[k] <= '0;
        csel[k] <= '0;
      end else if (wr && slot == 3'(k + 1)) begin
        if (is_val) creg[k] <= (creg[k] & ~csel[k]) | (wbits & csel[k]);
        else        csel[k] <= wbits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gen_en <= 1'b0;
    else if (wr && word == 4'd1) gen_en <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      in_sync <= '0;
    end else begin
      sync1   <= pad_i;
      in_sync <= sync1;
    end
  end

  wire [NPINS-1:0] pending = (in_sync ^ creg[R_IPOL]) & creg[R_IMSK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gen_en & (|pending);
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word == 4'd0)      bus_rdata[NPINS-1:0] = in_sync;
      else if (word == 4'd1) bus_rdata[0] = gen_en;
      else if (is_val)       bus_rdata[NPINS-1:0] = creg[int'(slot) - 1];
      else                   bus_rdata[NPINS-1:0] = csel[int'(slot) - 1];
    end
  end

  wire [NPINS-1:0] out_sel = csel[R_OUT];
  wire [NPINS-1:0] imask   = creg[R_IMSK];

  assign pad_o   = creg[R_OUT];
  assign pad_oe  = creg[R_OE];
  assign pad_alt = creg[R_ALT];
  assign pad_pu  = creg[R_PU];
  assign pad_pd  = creg[R_PD];
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk #(
  parameter int NPINS = 16,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] pad_i,
  input logic [NPINS-1:0] pad_o,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] in_sync,
  input logic             gen_en,
  input logic [NPINS-1:0] imask,
  input logic [NPINS-1:0] out_sel
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && !irq));

  assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == AW'(12)) |=>
      (((pad_o ^ $past(pad_o)) & ~$past(out_sel)) == '0));

  assert_two_flop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (in_sync == $past(pad_i, 2)));

  assert_unmasked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '0) |=> !irq);

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !irq);
endmodule

bind gpio_ctl gpio_ctl_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
  .irq(irq), .in_sync(in_sync), .gen_en(gen_en), .imask(imask),
  .out_sel(out_sel)
);

// File: tb/gpio_ctl_tb.sv
module gpio_ctl_tb;
  localparam int PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] pad_o, pad_oe, pad_pu, pad_pd, pad_alt;
  logic        irq;
  int          nchk = 0, nfail = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_alt(pad_alt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic mwr(input logic [5:0] base, input logic [31:0] m, input logic [31:0] v);
    wr(base, m);
    wr(base + 6'd4, v);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 pad_oe after reset", {16'b0, pad_oe}, 32'h0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    mwr(6'h08, 32'h00FF, 32'hA5A5);
    chk("R2 first masked write", {16'b0, pad_o}, 32'h00A5);
    mwr(6'h08, 32'hFF00, 32'h3C3C);
    chk("R2 second masked write", {16'b0, pad_o}, 32'h3CA5);
    rd(6'h08, d);
    chk("R2 mask word readback", d, 32'hFF00);
    rd(6'h0C, d);
    chk("R2 value word readback", d, 32'h3CA5);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    mwr(6'h10, 32'hFFFF, 32'h0F0F);
    chk("R3 pad_oe follows register", {16'b0, pad_oe}, 32'h0F0F);
    chk("R3 pad_o independent of oe", {16'b0, pad_o}, 32'h3CA5);
    @(negedge clk); pad_i = 16'h1234;
    @(negedge clk); @(negedge clk);
    rd(6'h00, d);
    chk("R4 input read regardless of oe", d, 32'h1234);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk); pad_i = 16'hBEEF;
    rd(6'h00, d);
    chk("R4 one edge: old level", d, 32'h1234);
    rd(6'h00, d);
    chk("R4 two edges: new level", d, 32'hBEEF);
  endtask

  task automatic t_irq;
    @(negedge clk); pad_i = 16'h0000;
    mwr(6'h38, 32'hFFFF, 32'h0000);
    wr(6'h04, 32'h1);
    mwr(6'h30, 32'h0008, 32'h0008);
    repeat (3) @(negedge clk);
    chk("R5 no pending at match", {31'b0, irq}, 32'h0);
    pad_i[5] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 unmasked pin silent", {31'b0, irq}, 32'h0);
    pad_i[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 irq not yet at 2nd edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 irq at 3rd edge", {31'b0, irq}, 32'h1);
    mwr(6'h38, 32'h0008, 32'h0008);
    @(negedge clk);
    chk("R6 polarity re-arm clears irq", {31'b0, irq}, 32'h0);
    pad_i[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 opposite edge fires again", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_gen;
    logic [31:0] d;
    wr(6'h04, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R7 gate off holds irq low", {31'b0, irq}, 32'h0);
    rd(6'h04, d);
    chk("R10 enable word only bit 0", d, 32'h0);
    wr(6'h04, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R7 gate on restores irq", {31'b0, irq}, 32'h1);
    mwr(6'h38, 32'h0008, 32'h0000);
    @(negedge clk);
    chk("R6 cleared by level match", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_pull;
    mwr(6'h20, 32'h00F0, 32'hFFFF);
    mwr(6'h28, 32'h000F, 32'hFFFF);
    mwr(6'h18, 32'h8001, 32'h8000);
    chk("R8 pull-up", {16'b0, pad_pu}, 32'h00F0);
    chk("R8 pull-down", {16'b0, pad_pd}, 32'h000F);
    chk("R8 alt function", {16'b0, pad_alt}, 32'h8000);
    mwr(6'h28, 32'h000F, 32'h0000);
    chk("R8 pull-down cleared", {16'b0, pad_pd}, 32'h0000);
    chk("R8 pull-up untouched", {16'b0, pad_pu}, 32'h00F0);
  endtask

  task automatic t_range;
    logic [31:0] d;
    mwr(6'h2C - 6'd4, 32'h0, 32'h0);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, d);
    chk("R10 upper bits dropped", d, 32'h0000_FFFF);
    rd(6'h08, d);
    chk("R10 mask upper bits dropped", d, 32'h0000_FFFF);
    rd(6'h0D, d);
    chk("R10 misaligned read zero", d, 32'h0);
    wr(6'h0D, 32'h0);
    chk("R10 misaligned write ignored", {16'b0, pad_o}, 32'hFFFF);
    wr(6'h00, 32'h0);
    rd(6'h00, d);
    chk("R10 input word not writable", d, {16'b0, pad_i});
    rd(6'h14, d);
    chk("R9 oe value at 0x14", d, 32'h0F0F);
    rd(6'h34, d);
    chk("R9 imask value at 0x34", d, 32'h0008);
  endtask

  initial begin
    #(PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked();
    t_dir();
    t_sync();
    t_irq();
    t_gen();
    t_pull();
    t_range();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule